// File: doc/BRIEF.md
# Buffered-Duty PWM Timer Channel

This block is one PWM timer channel for motor control. A 10-bit up-counter, advanced by a selectable power-of-two prescaler, runs against a 16-bit cycle register; the counter is always seen with its upper six bits set, so it counts upward from 16'hFC00. Eight outputs compare the counter's low ten bits against their own active duty values, and each output has a polarity bit that can invert its waveform.

Duty values are double-buffered. The host writes buffer registers at any time. When the counter reaches the cycle value on an advance, the counter restarts and every buffer is copied into its active duty register, so a duty change never splits a period. The host sets the run bit, the clock code, the cycle, the buffers and the polarity through a simple word-wide write/read port. The counter itself cannot be read or written.

Top module: `pwmt_channel`

## Requirements
- R1: After reset the run bit is 0, the clock code is 0, the cycle register reads 16'hFFFF, polarity and all duty buffers read 0, and every output is 0.
- R2: While the run bit is 0 the counter holds 16'hFC00 (low ten bits zero), active duty values are kept, and each output drives its polarity bit (raw level 0).
- R3: A prescaler counter starts at 0 at reset and counts every clock. With clock code k (0..7), the counter advances by one on each clock where the low k prescaler bits are all ones, so it advances once every 2^k clocks.
- R4: On an advance where the counter, with its upper six bits set, equals the cycle register, the counter returns to 16'hFC00 instead of incrementing. With any other cycle value, the low ten bits wrap from 1023 to 0.
- R5: On that same advance, every duty buffer is copied to its active duty register. A buffer write has no effect on any output before the next such match.
- R6: A write to the cycle register while the run bit is 1 is ignored, and the old value is kept.
- R7: A write of 16'hFC00 to the cycle register is rejected, and the old value is kept.
- R8: While running, output i is (low ten counter bits < active duty i) XOR polarity bit i.
- R9: Register map: address 0 holds run in bit 0 and the clock code in bits 3:1. Address 1 holds the cycle. Address 2 holds the polarity, with bit i for output i. Addresses 8 to 15 hold duty buffers 0 to 7 in bits 9:0. Every other address reads 0, so the counter is not visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for write and read |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Combinational read data at regAddr |
| pwmOut | output | 8 | PWM outputs, bit i is output i |

## Verification
The hardest case to reach from the ports is a cycle match that falls on a slow prescale code while the host is rewriting a buffer or trying to change the cycle. Both the transfer and the rejected write then depend on exactly which clock the advance lands on. The stimulus runs many short random periods just above 16'hFC00 with random clock codes. It scatters buffer writes and cycle writes through each run, and it compares every output on every clock with a cycle-accurate model. Directed cases add the rejected 16'hFC00 write, cycle values whose upper bits are not all ones (so the counter wraps), and the slowest clock code.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int NUM_OUT = 8;
  localparam int CNT_W   = 10;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 4;
  localparam int SEL_W   = 3;
  localparam int IDX_W   = $clog2(NUM_OUT);
  localparam int PRE_W   = (1 << SEL_W) - 1;
  localparam logic [REG_W-1:0] IDLE_VAL = {{(REG_W-CNT_W){1'b1}}, {CNT_W{1'b0}}};
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_CYC  = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_POL  = 4'd2;
  localparam int BUF_BASE = 8;

  typedef struct packed {
    logic             run;
    logic             tick;
    logic             cycWr;
    logic             polWr;
    logic             bufWr;
    logic [IDX_W-1:0] bufIdx;
    logic [REG_W-1:0] wrData;
  } strobe_t;
endpackage

// File: rtl/pwmt_ctrl.sv
module pwmt_ctrl
  import pwmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output strobe_t           strobes,
  output logic [REG_W-1:0]  ctrlWord
);
  logic             runReg;
  logic [SEL_W-1:0] selReg;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic             tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runReg <= 1'b0;
      selReg <= '0;
    end else if (regWrEn && regAddr == ADDR_CTRL) begin
      runReg <= regWrData[0];
      selReg <= regWrData[SEL_W:1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < PRE_W; i++) preMask[i] = (SEL_W'(i) < selReg);
  end

  assign tick = &(preCnt | ~preMask);

  always_comb begin
    strobes.run    = runReg;
    strobes.tick   = tick;
    strobes.cycWr  = regWrEn && regAddr == ADDR_CYC;
    strobes.polWr  = regWrEn && regAddr == ADDR_POL;
    strobes.bufWr  = regWrEn && regAddr[ADDR_W-1];
    strobes.bufIdx = regAddr[IDX_W-1:0];
    strobes.wrData = regWrData;
  end

  assign ctrlWord = {{(REG_W-SEL_W-1){1'b0}}, selReg, runReg};

  // R3: for any code above 0, two advances never fall on adjacent clocks
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (tick && selReg != '0 && !(regWrEn && regAddr == ADDR_CTRL)) |=> !tick);
  // R3: code 0 advances on every clock
  a_r3_full_rate: assert property (@(posedge clk) disable iff (!rstN)
    (selReg == '0) |-> tick);
endmodule

// File: rtl/pwmt_datapath.sv
module pwmt_datapath
  import pwmt_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  strobe_t                         strobes,
  output logic [REG_W-1:0]                cycleOut,
  output logic [NUM_OUT-1:0]              polOut,
  output logic [NUM_OUT-1:0][CNT_W-1:0]   bufOut,
  output logic [NUM_OUT-1:0]              pwmOut
);
  logic [CNT_W-1:0]               cntLow;
  logic [REG_W-1:0]               cnt16;
  logic [REG_W-1:0]               cycleReg;
  logic [NUM_OUT-1:0]             polReg;
  logic [NUM_OUT-1:0][CNT_W-1:0]  bufDuty;
  logic [NUM_OUT-1:0][CNT_W-1:0]  actDuty;
  logic                           match;
  logic                           reload;

  assign cnt16  = {{(REG_W-CNT_W){1'b1}}, cntLow};
  assign match  = (cnt16 == cycleReg);
  assign reload = strobes.run && strobes.tick && match;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cntLow <= '0;
    else if (!strobes.run)  cntLow <= '0;
    else if (strobes.tick)  cntLow <= match ? '0 : cntLow + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cycleReg <= '1;
    else if (strobes.cycWr && !strobes.run && strobes.wrData != IDLE_VAL)
      cycleReg <= strobes.wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              polReg <= '0;
    else if (strobes.polWr) polReg <= strobes.wrData[NUM_OUT-1:0];
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bufDuty[g] <= '0;
      else if (strobes.bufWr && strobes.bufIdx == IDX_W'(g))
        bufDuty[g] <= strobes.wrData[CNT_W-1:0];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       actDuty[g] <= '0;
      else if (reload) actDuty[g] <= bufDuty[g];
    end
    assign pwmOut[g] = (strobes.run && (cntLow < actDuty[g])) ^ polReg[g];
  end

  assign cycleOut = cycleReg;
  assign polOut   = polReg;
  assign bufOut   = bufDuty;

  a_r2_idle_counter: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.run |=> cntLow == '0);
  a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.run && !strobes.tick) |=> $stable(cntLow));
  a_r4_restart_on_match: assert property (@(posedge clk) disable iff (!rstN)
    reload |=> cntLow == '0);
  a_r5_transfer: assert property (@(posedge clk) disable iff (!rstN)
    reload |=> actDuty == $past(bufDuty));
  a_r5_active_held: assert property (@(posedge clk) disable iff (!rstN)
    !reload |=> $stable(actDuty));
  a_r6_locked_while_running: assert property (@(posedge clk) disable iff (!rstN)
    strobes.run |=> $stable(cycleReg));
  a_r7_never_idle_value: assert property (@(posedge clk) disable iff (!rstN)
    cycleReg != IDLE_VAL);
endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
  import pwmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  output logic [7:0]        pwmOut
);
  strobe_t                        strobes;
  logic [REG_W-1:0]               ctrlWord;
  logic [REG_W-1:0]               cycleOut;
  logic [NUM_OUT-1:0]             polOut;
  logic [NUM_OUT-1:0][CNT_W-1:0]  bufOut;

  pwmt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strobes(strobes), .ctrlWord(ctrlWord)
  );

  pwmt_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cycleOut(cycleOut),
    .polOut(polOut), .bufOut(bufOut), .pwmOut(pwmOut)
  );

  always_comb begin
    regRdData = '0;
    if (regAddr[ADDR_W-1])
      regRdData = {{(REG_W-CNT_W){1'b0}}, bufOut[regAddr[IDX_W-1:0]]};
    else if (regAddr == ADDR_CTRL) regRdData = ctrlWord;
    else if (regAddr == ADDR_CYC)  regRdData = cycleOut;
    else if (regAddr == ADDR_POL)  regRdData = {{(REG_W-NUM_OUT){1'b0}}, polOut};
  end

  // R2: stopped outputs sit at the polarity level
  a_r2_idle_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWord[0] |-> pwmOut == polOut);
endmodule

// File: tb/pwmt_channel_tb.sv
module pwmt_channel_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [7:0]  pwmOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  bit modelOn = 1'b0;

  // reference model state
  logic       mRun;
  logic [2:0] mSel;
  logic [15:0] mCyc;
  logic [7:0] mPol;
  logic [9:0] mBuf [8];
  logic [9:0] mAct [8];
  logic [9:0] mCnt;
  logic [6:0] mPre;

  always #2 clk = ~clk;

  pwmt_channel u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pwmOut(pwmOut)
  );

  function automatic logic modelTick();
    logic [6:0] mask;
    for (int i = 0; i < 7; i++) mask[i] = (i < int'(mSel));
    return &(mPre | ~mask);
  endfunction

  function automatic logic [7:0] expOut();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = (mRun && (mCnt < mAct[i])) ^ mPol[i];
    return r;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRun <= 0; mSel <= 0; mCyc <= 16'hFFFF; mPol <= 0; mCnt <= 0; mPre <= 0;
      for (int i = 0; i < 8; i++) begin mBuf[i] <= 0; mAct[i] <= 0; end
    end else begin
      mPre <= mPre + 1'b1;
      if (!mRun) mCnt <= 0;
      else if (modelTick()) begin
        if ({6'h3F, mCnt} == mCyc) begin
          mCnt <= 0;
          for (int i = 0; i < 8; i++) mAct[i] <= mBuf[i];
        end else mCnt <= mCnt + 1'b1;
      end
      if (regWrEn) begin
        if (regAddr == 0) begin mRun <= regWrData[0]; mSel <= regWrData[3:1]; end
        else if (regAddr == 1 && !mRun && regWrData != 16'hFC00) mCyc <= regWrData;
        else if (regAddr == 2) mPol <= regWrData[7:0];
        else if (regAddr >= 8) mBuf[regAddr - 8] <= regWrData[9:0];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every clock: outputs vs model (R8, also R2 R4 R5 R3 through the waveform)
  always @(negedge clk) begin
    if (modelOn && rstN) begin
      logic [7:0] e;
      e = expOut();
      check(pwmOut === e, mRun ? "R8 waveform" : "R2 idle level", {8'h0, pwmOut}, {8'h0, e});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdCheck(input logic [3:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    check(regRdData === exp, tag, regRdData, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check(pwmOut === 8'h00, "R1 outputs", {8'h0, pwmOut}, 16'h0);
    rdCheck(4'd0, 16'h0000, "R1 control");
    rdCheck(4'd1, 16'hFFFF, "R1 cycle");
    rdCheck(4'd2, 16'h0000, "R1 polarity");
    rdCheck(4'd9, 16'h0000, "R1 buffer");
    modelOn = 1'b1;

    // R9 map, counter not visible
    wr(4'd2, 16'h00A5); rdCheck(4'd2, 16'h00A5, "R9 polarity readback");
    wr(4'd11, 16'hFFFF); rdCheck(4'd11, 16'h03FF, "R9 buffer field 9:0");
    wr(4'd0, 16'h000A); rdCheck(4'd0, 16'h000A, "R9 control fields");
    wr(4'd0, 16'h0000);
    // R7 reject FC00
    wr(4'd1, 16'hFC05);
    wr(4'd1, 16'hFC00); rdCheck(4'd1, 16'hFC05, "R7 FC00 rejected");
    // R6 write while running ignored
    wr(4'd8, 16'd3);
    wr(4'd0, 16'h0001);
    idle(5);
    rdCheck(4'd3, 16'h0000, "R9 counter not readable");
    wr(4'd1, 16'hFC10); rdCheck(4'd1, 16'hFC05, "R6 cycle locked while running");
    idle(30);
    // R3 slowest code
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'hFC02);
    wr(4'd0, 16'h000F);
    idle(800);
    // R4 cycle with low upper bits: counter wraps, no transfer
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'h0010);
    wr(4'd0, 16'h0001);
    idle(1100);
    wr(4'd0, 16'h0000);
    idle(3);

    // random runs (R3 R4 R5 R6 R8)
    for (int it = 0; it < 60; it++) begin
      logic [15:0] cyc;
      wr(4'd0, 16'h0000);
      idle(2);
      cyc = ($urandom % 6 == 0) ? 16'hFC00 : 16'hFC00 + 16'($urandom % 40);
      wr(4'd1, cyc);
      wr(4'd2, 16'($urandom % 256));
      for (int k = 0; k < 8; k++) wr(4'(8 + k), 16'($urandom % 48));
      wr(4'd0, {12'h0, 3'($urandom % 4), 1'b1});
      for (int s = 0; s < 20; s++) begin
        int pick;
        pick = $urandom % 5;
        if (pick == 0) wr(4'(8 + $urandom % 8), 16'($urandom % 48));
        else if (pick == 1) wr(4'd1, 16'hFC00 + 16'($urandom % 40));
        else if (pick == 2) wr(4'd2, 16'($urandom % 256));
        else idle(1 + $urandom % 25);
      end
    end
    wr(4'd0, 16'h0000);
    idle(4);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule